// File: doc/BRIEF.md
# Boot ROM/RAM Bank Overlay Controller

This block sits on an 8-bit CPU bus with separate memory and I/O strobes. It decides which memory chip answers in the two lowest 16K windows of a 64K address space. The bottom window can be served by a 16K boot ROM or by the lower half of a 32K RAM. The window above it always reaches the upper half of that same RAM. A single overlay bit makes the choice, and the CPU writes that bit through an I/O port.

After reset the overlay bit reads zero, so the CPU fetches its first instructions from ROM. Boot code can copy what it needs into RAM and then write 0x01 to the port. From then on the bottom window is RAM, which a disk-based operating system needs. By default the port decode is partial: the three low port-address bits are not compared, so the port also answers at seven aliased addresses. A parameter selects full decoding to the base port only.

The strobes mreq_n, iorq_n, rd_n and wr_n are active low. The I/O port number is taken from addr[7:0]. Chip enables and RAM address bit 14 are combinational from the bus and the overlay bit. The overlay bit itself is a register on the bus clock.

Top module: `bank_overlay_ctrl`

## Requirements
- R1: With the overlay bit clear (ROM mode), a memory read (mreq_n=0, wr_n=1) at 0x0000–0x3FFF drives rom_ce_n low and ram_ce_n high.
- R2: A memory access at 0x4000–0x7FFF drives ram_ce_n low, ram_a14 high and rom_ce_n high, whatever the overlay bit is.
- R3: An I/O write (iorq_n=0, wr_n=0) of 0x00 to a decoded port address clears the overlay bit at the next rising clock edge. The overlay bit is 0 = ROM, 1 = RAM.
- R4: An I/O write of 0x01 to a decoded port address sets the overlay bit at the next rising clock edge. In RAM mode, memory reads and writes at 0x0000–0x3FFF drive ram_ce_n low, ram_a14 low and rom_ce_n high.
- R5: A low rst_n clears the overlay bit at once, without waiting for a clock edge. Port writes take effect only from the third rising edge after rst_n returns high.
- R6: With the default partial decode, every port address 0x00–0x07 reaches the overlay bit and 0x08 does not. With FULL_DECODE=1, only port 0x00 does.
- R7: In ROM mode, a memory write (mreq_n=0, wr_n=0) at 0x0000–0x3FFF leaves both rom_ce_n and ram_ce_n high.
- R8: Only data bit 0 is stored, and data bits 7:1 are ignored. Writing 0xFE selects ROM mode and writing 0xFF selects RAM mode.
- R9: No chip enable is driven low while mreq_n is high, or for any address at 0x8000 or above. ram_a14 is low whenever ram_ce_n is high.
- R10: An I/O read (iorq_n=0, rd_n=0) of a decoded port drives data_oe high and returns the overlay bit in data_out bit 0, with bits 7:1 zero. data_oe is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| addr | input | 16 | CPU address bus; bits 7:0 give the I/O port number |
| data_in | input | 8 | CPU write data |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| data_out | output | 8 | Port read data; bit 0 holds the overlay bit |
| data_oe | output | 1 | High while data_out should drive the bus |
| rom_ce_n | output | 1 | Boot ROM chip enable, active low |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_a14 | output | 1 | RAM address bit 14 (bank select within the RAM) |

## Verification
Chip enables, ram_a14 and the port read data are combinational, so they are due in the same cycle as the bus inputs that cause them. A port write changes the overlay bit one rising edge after it is presented. The bench applies each bus cycle at the falling edge and updates its reference model at the rising edge. It compares every output one time unit after that edge, so a write shows up in the cycle that follows it. Reset release adds two more edges of delay. The model counts those edges itself, and writes issued inside that window must be ignored.

// File: rtl/bank_overlay_pkg.sv
package bank_overlay_pkg;

  typedef enum logic {
    MODE_ROM = 1'b0,
    MODE_RAM = 1'b1
  } overlay_mode_e;

  typedef struct packed {
    logic rom_ce;
    logic ram_ce;
    logic ram_a14;
  } mem_sel_t;

  // Window index of an address: the bits above the window offset.
  function automatic int unsigned window_of(input logic [15:0] a, input int unsigned win_aw);
    return int'(a >> win_aw);
  endfunction

  // Select for one memory cycle.
  function automatic mem_sel_t select_mem(input logic active, input logic is_wr,
                                          input int unsigned win, input overlay_mode_e mode);
    mem_sel_t s;
    s = '0;
    if (active) begin
      if (win == 1) begin
        s.ram_ce  = 1'b1;
        s.ram_a14 = 1'b1;
      end else if (win == 0) begin
        if (mode == MODE_RAM) s.ram_ce = 1'b1;
        else if (!is_wr)      s.rom_ce = 1'b1;
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/bank_overlay_rst_sync.sv
module bank_overlay_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/bank_overlay_port_dec.sv
module bank_overlay_port_dec #(
  parameter int          PORT_AW     = 8,
  parameter logic [7:0]  PORT_BASE   = 8'h00,
  parameter int          ALIAS_BITS  = 3,
  parameter bit          FULL_DECODE = 1'b0
) (
  input  logic [PORT_AW-1:0] port_addr,
  input  logic               iorq_n,
  input  logic               rd_n,
  input  logic               wr_n,
  output logic               port_wr,
  output logic               port_rd
);
  logic hit;

  generate
    if (FULL_DECODE) begin : g_full
      assign hit = (port_addr == PORT_BASE[PORT_AW-1:0]);
    end else begin : g_partial
      assign hit = (port_addr[PORT_AW-1:ALIAS_BITS] == PORT_BASE[PORT_AW-1:ALIAS_BITS]);
    end
  endgenerate

  assign port_wr = hit && !iorq_n && !wr_n;
  assign port_rd = hit && !iorq_n && !rd_n;
endmodule

// File: rtl/bank_overlay_mode_reg.sv
module bank_overlay_mode_reg
  import bank_overlay_pkg::*;
(
  input  logic          clk,
  input  logic          rst_sync_n,
  input  logic          port_wr,
  input  logic          wdata_b0,
  output overlay_mode_e mode
);
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mode <= MODE_ROM;
    else if (port_wr) mode <= overlay_mode_e'(wdata_b0);
  end
endmodule

// File: rtl/bank_overlay_ctrl.sv
module bank_overlay_ctrl
  import bank_overlay_pkg::*;
#(
  parameter int         ADDR_W      = 16,
  parameter int         DATA_W      = 8,
  parameter int         WIN_AW      = 14,
  parameter int         PORT_AW     = 8,
  parameter logic [7:0] PORT_BASE   = 8'h00,
  parameter int         ALIAS_BITS  = 3,
  parameter bit         FULL_DECODE = 1'b0,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              rom_ce_n,
  output logic              ram_ce_n,
  output logic              ram_a14
);
  localparam int WIN_COUNT = 1 << (ADDR_W - WIN_AW);

  logic          rst_sync_n;
  logic          port_wr;
  logic          port_rd;
  overlay_mode_e mode;
  mem_sel_t      sel;
  int unsigned   win;

  bank_overlay_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bank_overlay_port_dec #(
    .PORT_AW     (PORT_AW),
    .PORT_BASE   (PORT_BASE),
    .ALIAS_BITS  (ALIAS_BITS),
    .FULL_DECODE (FULL_DECODE)
  ) u_dec (
    .port_addr (addr[PORT_AW-1:0]),
    .iorq_n    (iorq_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .port_wr   (port_wr),
    .port_rd   (port_rd)
  );

  bank_overlay_mode_reg u_mode (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .port_wr    (port_wr),
    .wdata_b0   (data_in[0]),
    .mode       (mode)
  );

  always_comb begin
    win = window_of(16'(addr), WIN_AW);
    if (win >= WIN_COUNT) win = WIN_COUNT;
    sel = select_mem(!mreq_n, !wr_n, win, mode);
  end

  assign rom_ce_n = !sel.rom_ce;
  assign ram_ce_n = !sel.ram_ce;
  assign ram_a14  = sel.ram_a14;
  assign data_oe  = port_rd;
  assign data_out = port_rd ? {{(DATA_W-1){1'b0}}, mode} : '0;
endmodule

// File: rtl/bank_overlay_ctrl_chk.sv
module bank_overlay_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rst_sync_n,
  input logic [15:0] addr,
  input logic [7:0]  data_in,
  input logic        mreq_n,
  input logic        wr_n,
  input logic        port_wr,
  input logic        mode,
  input logic        rom_ce_n,
  input logic        ram_ce_n,
  input logic        ram_a14
);
  p_bank1_ram_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && addr[15:14] == 2'b01) |-> (!ram_ce_n && ram_a14 && rom_ce_n));

  p_clear_rom_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (port_wr && !data_in[0]) |=> !mode);

  p_set_ram_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (port_wr && data_in[0]) |=> mode);

  p_reset_rom_r5: assert property (@(posedge clk) !rst_n |-> !mode);

  p_rom_wr_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && !wr_n && addr[15:14] == 2'b00 && !mode) |-> (rom_ce_n && ram_ce_n));

  p_excl_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_ce_n && !ram_ce_n));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_n || addr[15]) |-> (rom_ce_n && ram_ce_n && !ram_a14));
endmodule

bind bank_overlay_ctrl bank_overlay_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .addr       (addr),
  .data_in    (data_in),
  .mreq_n     (mreq_n),
  .wr_n       (wr_n),
  .port_wr    (port_wr),
  .mode       (mode),
  .rom_ce_n   (rom_ce_n),
  .ram_ce_n   (ram_ce_n),
  .ram_a14    (ram_a14)
);

// File: tb/bank_overlay_ctrl_tb.sv
module bank_overlay_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data_in = '0;
  logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  data_out, f_data_out;
  logic        data_oe, rom_ce_n, ram_ce_n, ram_a14;
  logic        f_data_oe, f_rom_ce_n, f_ram_ce_n, f_ram_a14;

  int compared = 0, mismatched = 0;
  int mode_p = 0, mode_f = 0, rst_edges = 0;
  string tag = "R0";

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_overlay_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .data_out(data_out), .data_oe(data_oe),
    .rom_ce_n(rom_ce_n), .ram_ce_n(ram_ce_n), .ram_a14(ram_a14));

  bank_overlay_ctrl #(.FULL_DECODE(1'b1)) u_dut_full (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .data_out(f_data_out), .data_oe(f_data_oe),
    .rom_ce_n(f_rom_ce_n), .ram_ce_n(f_ram_ce_n), .ram_a14(f_ram_a14));

  function automatic bit hit_port(input logic [15:0] a, input bit full);
    int p = a % 256;
    return full ? (p == 0) : (p < 8);
  endfunction

  task automatic check(input string name, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, name, act, exp);
    end
  endtask

  task automatic compare_side(input string pfx, input int mode,
                              input logic oe, input logic [7:0] dout,
                              input logic rce, input logic mce, input logic a14, input bit full);
    int w = addr / 16384;
    bit mem = !mreq_n, wr = !wr_n;
    int e_rom = 0, e_ram = 0, e_a14 = 0, e_oe = 0;
    if (mem && w == 1) begin e_ram = 1; e_a14 = 1; end
    if (mem && w == 0) begin
      if (mode == 1) e_ram = 1;
      else if (!wr)  e_rom = 1;
    end
    e_oe = (!iorq_n && !rd_n && hit_port(addr, full)) ? 1 : 0;
    check({pfx, "rom_ce"}, int'(!rce), e_rom);
    check({pfx, "ram_ce"}, int'(!mce), e_ram);
    check({pfx, "ram_a14"}, int'(a14), e_a14);
    check({pfx, "data_oe"}, int'(oe), e_oe);
    if (e_oe == 1) check({pfx, "data_out"}, int'(dout), mode);
  endtask

  // Reference model update at each rising edge, then compare.
  always @(posedge clk) begin
    if (rst_n) begin
      if (rst_edges >= 2 && !iorq_n && !wr_n) begin
        if (hit_port(addr, 1'b0)) mode_p = data_in % 2;
        if (hit_port(addr, 1'b1)) mode_f = data_in % 2;
      end
      if (rst_edges < 2) rst_edges++;
    end
    #1;
    compare_side("", mode_p, data_oe, data_out, rom_ce_n, ram_ce_n, ram_a14, 1'b0);
    compare_side("full.", mode_f, f_data_oe, f_data_out, f_rom_ce_n, f_ram_ce_n, f_ram_a14, 1'b1);
  end

  always @(negedge rst_n) begin mode_p = 0; mode_f = 0; rst_edges = 0; end

  task automatic bus(input string t, input bit m, input bit io, input bit rd, input bit wr,
                     input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    tag = t; mreq_n = !m; iorq_n = !io; rd_n = !rd; wr_n = !wr; addr = a; data_in = d;
  endtask

  task automatic io_wr(input string t, input logic [15:0] a, input logic [7:0] d);
    bus(t, 0, 1, 0, 1, a, d);
    bus(t, 0, 0, 0, 0, 16'h0, 8'h0);
  endtask

  task automatic mem_sweep(input string t);
    bus(t, 1, 0, 1, 0, 16'h0000, 8'h0);
    bus(t, 1, 0, 0, 1, 16'h3FFF, 8'h0);
    bus(t, 1, 0, 1, 0, 16'h4000, 8'h0);
    bus(t, 1, 0, 0, 1, 16'h7FFF, 8'h0);
    bus(t, 1, 0, 1, 0, 16'h8000, 8'h0);
    bus(t, 0, 0, 1, 0, 16'h1234, 8'h0);
    bus(t, 0, 1, 1, 0, 16'h0003, 8'h0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    mismatched++; compared++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R5"; rst_n = 1'b1;
    io_wr("R5", 16'h0000, 8'h01);      // inside release window: ignored
    repeat (2) bus("R5", 0, 0, 0, 0, 16'h0, 8'h0);
    mem_sweep("R1");                    // ROM mode reads, bank 1, idle
    mem_sweep("R7");                    // ROM-mode writes blocked
    io_wr("R4", 16'h0000, 8'h01);
    mem_sweep("R4");
    mem_sweep("R2");
    io_wr("R3", 16'h0000, 8'h00);
    mem_sweep("R3");
    io_wr("R8", 16'h0000, 8'hFF);
    mem_sweep("R8");
    io_wr("R8", 16'h0000, 8'hFE);
    mem_sweep("R8");
    for (int p = 1; p < 10; p++) begin
      io_wr("R6", 16'(p) | 16'hA500, 8'(p % 2));
      mem_sweep("R6");
    end
    io_wr("R10", 16'h0005, 8'h01);
    for (int p = 0; p < 12; p++) bus("R10", 0, 1, 1, 0, 16'(p), 8'h0);
    bus("R9", 0, 0, 0, 1, 16'h2000, 8'h0);
    bus("R9", 1, 0, 1, 0, 16'hC000, 8'h0);
    @(negedge clk); @(negedge clk);
    #2; tag = "R5"; rst_n = 1'b0;
    bus("R5", 1, 0, 1, 0, 16'h0100, 8'h0);
    #2; rst_n = 1'b1;
    io_wr("R5", 16'h0000, 8'h01);
    mem_sweep("R5");
    io_wr("R5", 16'h0000, 8'h01);
    mem_sweep("R5");
    bus("R0", 0, 0, 0, 0, 16'h0, 8'h0);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule